// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A free-running enable, `tick16`, pulses sixteen times per bit period. The block watches for a falling edge on the line and confirms the start bit half a bit later. It then samples 5 to 8 data bits, least significant bit first, and waits one stop-bit time.

The finished character moves into a holding register in one step. The next character can then arrive while the consumer still has the previous one to read.

The holding register raises `data_ready` when it loads. A read strobe lowers `data_ready`. A new character that arrives before the old one is read replaces it and raises `overrun`. `overrun` stays set until a separate status strobe clears it.

Top module: `uart_rx_dbuf`

## Requirements
- R1: `char_len` selects the number of data bits per character: code 0 = 5, 1 = 6, 2 = 7, 3 = 8. The code is captured when the start bit is confirmed.
- R2: The first data bit on the line lands in `rx_data[0]`, and later bits fill the next higher positions, so short characters are right-justified.
- R3: For a character of n bits, `rx_data` bits n and above read as 0.
- R4: A low level on the line is taken as a start bit only if the line is still low 8 ticks after the falling edge was seen. Otherwise the receiver returns to idle, no character is delivered, and a later valid frame is still received.
- R5: Data bits are sampled every 16 ticks after the start-bit midpoint, and one stop bit is sampled 16 ticks after the last data bit. The character is delivered at that stop-bit sample. With `tick16` high on every cycle, `data_ready` is seen rising between 16·(n+1)+8 and 16·(n+1)+12 cycles after the start bit is driven.
- R6: When a character completes, all of its bits enter `rx_data` in the same cycle and `data_ready` is set on the next clock edge.
- R7: A `buf_rd` pulse with no character completing clears `data_ready`. It leaves `overrun` and `rx_data` unchanged.
- R8: If a character completes while `data_ready` is set and `buf_rd` is low, the new character replaces the old one and `overrun` is set.
- R9: A `stat_rd` pulse clears `overrun` unless an overrun occurs in the same cycle. It does not change `data_ready`.
- R10: If `buf_rd` falls in the same cycle as a character completing, the new character is kept, `data_ready` stays 1, and no overrun is flagged.
- R11: If `stat_rd` falls in the same cycle as a new overrun, `overrun` ends up set.
- R12: After reset, `data_ready` and `overrun` are 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Enable pulsing 16 times per bit period |
| char_len | input | LEN_W | Character length code (0..3 = 5..8 bits) |
| buf_rd | input | 1 | Holding-register read strobe |
| stat_rd | input | 1 | Status read strobe, clears the overrun flag |
| rx_data | output | MAX_BITS | Holding register, right-justified |
| data_ready | output | 1 | Unread character is held |
| overrun | output | 1 | A character was lost since the last status read |

## Verification
The risky overlap is a read strobe, or a status strobe, landing in the same cycle in which a finished character is loaded into the holding register. The bench first measures the load cycle on a clean 8-bit frame, observing only at the ports. It then repeats a frame of the same length with `buf_rd` placed exactly on that cycle and, separately, one cycle before it. It also places `stat_rd` on that cycle while an unread character is held. The bench judges each case from the final `data_ready`, `overrun` and `rx_data`: the read must not clear the flag for the new character, no overrun may appear, and the status clear must lose to the new overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("rx_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_frame.sv
module rx_frame
   import uart_rx_pkg::*;
#(
   parameter int MAX_BITS = 8,
   parameter int MIN_BITS = 5,
   parameter int LEN_W    = 2,
   parameter int OSR      = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                rxs,
   input  logic [LEN_W-1:0]    len_sel,
   output logic                done,
   output logic [MAX_BITS-1:0] word
);
   localparam int CNT_W = $clog2(OSR);
   localparam int HALF  = OSR / 2;
   localparam int BIT_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
   localparam int NB_W  = $clog2(MAX_BITS + 1);

   generate
      if (MIN_BITS < 1 || MIN_BITS > MAX_BITS) begin : g_chk_len
         $error("rx_frame: MIN_BITS out of range");
      end
      if ((MAX_BITS - MIN_BITS + 1) > (1 << LEN_W)) begin : g_chk_sel
         $error("rx_frame: LEN_W too narrow for the length range");
      end
      if (OSR < 4 || (OSR % 2) != 0 || (1 << CNT_W) != OSR) begin : g_chk_osr
         $error("rx_frame: OSR must be a power of two of at least 4");
      end
   endgenerate

   rx_state_e            state;
   logic [CNT_W-1:0]     cnt;
   logic [BIT_W-1:0]     bitn;
   logic [NB_W-1:0]      nbits_q;
   logic [NB_W-1:0]      nb_sel;
   logic [NB_W-1:0]      shamt;
   logic [MAX_BITS-1:0]  sr;
   logic                 mid_start;
   logic                 bit_end;

   always_comb begin
      int tmp;
      tmp = MIN_BITS + int'(len_sel);
      if (tmp > MAX_BITS) nb_sel = NB_W'(MAX_BITS);
      else                nb_sel = NB_W'(tmp);
   end

   assign mid_start = tick && (cnt == CNT_W'(HALF - 1));
   assign bit_end   = tick && (cnt == CNT_W'(OSR - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         cnt     <= '0;
         bitn    <= '0;
         nbits_q <= NB_W'(MAX_BITS);
         sr      <= '0;
      end else begin
         case (state)
            RX_IDLE: begin
               if (tick && !rxs) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (mid_start) begin
                  cnt     <= '0;
                  bitn    <= '0;
                  nbits_q <= nb_sel;
                  state   <= rxs ? RX_IDLE : RX_DATA;
               end else if (tick) begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_DATA: begin
               if (bit_end) begin
                  cnt <= '0;
                  sr  <= {rxs, sr[MAX_BITS-1:1]};
                  if (NB_W'(bitn) == nbits_q - NB_W'(1)) state <= RX_STOP;
                  else                                   bitn  <= bitn + BIT_W'(1);
               end else if (tick) begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            RX_STOP: begin
               if (bit_end) begin
                  cnt   <= '0;
                  state <= RX_IDLE;
               end else if (tick) begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign done  = (state == RX_STOP) && bit_end;
   assign shamt = NB_W'(MAX_BITS) - nbits_q;
   assign word  = sr >> shamt;

   // R4: a line back high at the start midpoint aborts the frame
   a_r4_false_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && mid_start && rxs) |=> (state == RX_IDLE));

   // R1: bit index never reaches the captured length
   a_r1_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_DATA) |-> (NB_W'(bitn) < nbits_q));

   // R3: upper bits of a delivered short character are zero
   a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((word >> nbits_q) == '0));

   // R5: delivery ends the frame
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (state == RX_IDLE));
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
   parameter int MAX_BITS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [MAX_BITS-1:0] din,
   input  logic                rd,
   input  logic                st_rd,
   output logic [MAX_BITS-1:0] dout,
   output logic                dr,
   output logic                ov
);
   logic ov_evt;
   assign ov_evt = load && dr && !rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         dr   <= 1'b0;
         ov   <= 1'b0;
      end else begin
         if (load)    dout <= din;
         if (load)    dr   <= 1'b1;
         else if (rd) dr   <= 1'b0;
         if (ov_evt)     ov <= 1'b1;
         else if (st_rd) ov <= 1'b0;
      end
   end

   // R6: a load publishes the character and raises the flag
   a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dr && dout == $past(din)));

   // R7: a plain read lowers the flag and keeps overrun
   a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !load) |=> !dr);
   a_r7_ov_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !st_rd && ov) |=> ov);

   // R8: loading over an unread character flags overrun
   a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (load && dr && !rd) |=> ov);

   // R9: status read clears overrun when no new one arrives
   a_r9_status_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (st_rd && !(load && dr && !rd)) |=> !ov);

   // R10: read colliding with load keeps the new character flagged
   a_r10_collide: assert property (@(posedge clk) disable iff (!rst_n)
      (load && rd && !st_rd) |=> (dr && ov == $past(ov)));
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
   parameter int MAX_BITS    = 8,
   parameter int MIN_BITS    = 5,
   parameter int LEN_W       = 2,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rxd,
   input  logic                tick16,
   input  logic [LEN_W-1:0]    char_len,
   input  logic                buf_rd,
   input  logic                stat_rd,
   output logic [MAX_BITS-1:0] rx_data,
   output logic                data_ready,
   output logic                overrun
);
   logic                rxs;
   logic                done;
   logic [MAX_BITS-1:0] word;

   rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
   );

   rx_frame #(
      .MAX_BITS(MAX_BITS), .MIN_BITS(MIN_BITS), .LEN_W(LEN_W), .OSR(OSR)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rxs(rxs),
      .len_sel(char_len), .done(done), .word(word)
   );

   rx_hold #(.MAX_BITS(MAX_BITS)) u_hold (
      .clk(clk), .rst_n(rst_n), .load(done), .din(word),
      .rd(buf_rd), .st_rd(stat_rd),
      .dout(rx_data), .dr(data_ready), .ov(overrun)
   );
endmodule

// File: tb/tb_uart_rx_dbuf.sv
module tb_uart_rx_dbuf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rxd = 1'b1;
   logic       tick16 = 1'b0;
   logic [1:0] char_len = 2'd0;
   logic       buf_rd = 1'b0;
   logic       stat_rd = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready;
   logic       overrun;

   int n_chk = 0;
   int n_bad = 0;
   int lat   = -1;
   int lat8  = 26 + 16 * 8;

   always #10 clk = ~clk;

   uart_rx_dbuf dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
      .char_len(char_len), .buf_rd(buf_rd), .stat_rd(stat_rd),
      .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun)
   );

   // {len code[17:16], data[15:8], tick divisor[7:0]}
   localparam logic [17:0] VEC [0:7] = '{
      {2'd0, 8'hE5, 8'd1}, {2'd1, 8'hFF, 8'd1}, {2'd2, 8'h81, 8'd1},
      {2'd3, 8'hA5, 8'd1}, {2'd3, 8'h3C, 8'd3}, {2'd0, 8'h1A, 8'd3},
      {2'd2, 8'h7E, 8'd1}, {2'd1, 8'hD2, 8'd3}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic send(input int lc, input logic [7:0] d, input int div,
                       input int rd_at, input int st_at);
      int  n;
      int  total;
      bit  prev;
      n     = 5 + lc;
      total = 16 * div * (n + 2);
      lat   = -1;
      char_len = 2'(lc);
      prev  = data_ready;
      for (int c = 0; c < total; c++) begin
         int bi;
         @(negedge clk);
         if (data_ready && !prev && lat < 0) lat = c;
         prev = data_ready;
         bi = c / (16 * div);
         rxd     = (bi == 0) ? 1'b0 : (bi <= n) ? d[bi-1] : 1'b1;
         tick16  = ((c % div) == 0);
         buf_rd  = (c == rd_at);
         stat_rd = (c == st_at);
      end
      @(negedge clk);
      rxd = 1'b1; tick16 = 1'b0; buf_rd = 1'b0; stat_rd = 1'b0;
   endtask

   task automatic strobe(input bit rd, input bit st);
      @(negedge clk);
      buf_rd = rd; stat_rd = st;
      @(negedge clk);
      buf_rd = 1'b0; stat_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] last;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk(data_ready == 1'b0, "R12", "data_ready", data_ready, 0);
      chk(overrun == 1'b0, "R12", "overrun", overrun, 0);
      chk(rx_data == 8'h00, "R12", "rx_data", rx_data, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3 R5 R6 R7: vector table
      last = 8'h00;
      foreach (VEC[i]) begin
         int         lc;
         int         div;
         int         n;
         logic [7:0] d;
         logic [7:0] exp;
         lc  = int'(VEC[i][17:16]);
         d   = VEC[i][15:8];
         div = int'(VEC[i][7:0]);
         n   = 5 + lc;
         exp = d & 8'((1 << n) - 1);
         send(lc, d, div, -1, -1);
         chk(rx_data == exp, "R1/R2/R3", "rx_data", rx_data, exp);
         chk(data_ready == 1'b1, "R6", "data_ready", data_ready, 1);
         chk(overrun == 1'b0, "R8", "overrun", overrun, 0);
         if (div == 1) begin
            chk(lat >= 16 * (n + 1) + 8 && lat <= 16 * (n + 1) + 12,
                "R5", "latency", lat, 16 * (n + 1) + 8);
            if (n == 8) lat8 = lat;
         end
         strobe(1'b1, 1'b0);
         chk(data_ready == 1'b0, "R7", "data_ready after read", data_ready, 0);
         chk(rx_data == exp, "R7", "rx_data kept", rx_data, exp);
         last = exp;
      end

      // R4: short low pulse is rejected
      char_len = 2'd3;
      for (int c = 0; c < 48; c++) begin
         @(negedge clk);
         rxd = (c < 5) ? 1'b0 : 1'b1;
         tick16 = 1'b1;
      end
      @(negedge clk); tick16 = 1'b0;
      chk(data_ready == 1'b0, "R4", "no char after glitch", data_ready, 0);
      chk(rx_data == last, "R4", "rx_data unchanged", rx_data, last);
      send(3, 8'h5A, 1, -1, -1);
      chk(rx_data == 8'h5A, "R4", "frame after glitch", rx_data, 8'h5A);

      // R8: overwrite of unread character
      send(3, 8'hC3, 1, -1, -1);
      chk(rx_data == 8'hC3, "R8", "rx_data replaced", rx_data, 8'hC3);
      chk(data_ready == 1'b1, "R8", "data_ready", data_ready, 1);
      chk(overrun == 1'b1, "R8", "overrun", overrun, 1);

      // R7: read keeps overrun
      strobe(1'b1, 1'b0);
      chk(data_ready == 1'b0, "R7", "data_ready", data_ready, 0);
      chk(overrun == 1'b1, "R7", "overrun kept", overrun, 1);

      // R9: status read clears overrun, not data_ready
      send(1, 8'h15, 1, -1, -1);
      chk(overrun == 1'b1, "R9", "overrun still set before status read", overrun, 1);
      strobe(1'b0, 1'b1);
      chk(overrun == 1'b0, "R9", "overrun cleared", overrun, 0);
      chk(data_ready == 1'b1, "R9", "data_ready kept", data_ready, 1);

      // R10: read in the load cycle
      send(3, 8'h96, 1, lat8 - 1, -1);
      chk(rx_data == 8'h96, "R10", "rx_data", rx_data, 8'h96);
      chk(data_ready == 1'b1, "R10", "data_ready", data_ready, 1);
      chk(overrun == 1'b0, "R10", "overrun", overrun, 0);

      // R10: read one cycle before the load
      send(3, 8'h69, 1, lat8 - 2, -1);
      chk(data_ready == 1'b1, "R10", "data_ready (early read)", data_ready, 1);
      chk(overrun == 1'b0, "R10", "overrun (early read)", overrun, 0);

      // R11: status read in the overrun cycle
      send(3, 8'h33, 1, -1, lat8 - 1);
      chk(rx_data == 8'h33, "R11", "rx_data", rx_data, 8'h33);
      chk(overrun == 1'b1, "R11", "overrun wins", overrun, 1);
      strobe(1'b0, 1'b1);
      chk(overrun == 1'b0, "R9", "overrun cleared later", overrun, 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule